// File: doc/BRIEF.md
# PCI Host Bridge Register Controller

This block is the CPU-facing register front end of a small PCI host bridge. A 32-bit request/acknowledge register bus reaches it through two equivalent register windows and one IO aperture. The windows contain the bridge's own 256-byte configuration header, a configuration address latch, a masked memory base, a masked IO base and a configuration data port. A CPU access to the data port becomes a 4-byte configuration transaction on a downstream request/acknowledge channel, aimed at the address held in the latch.

A CPU access that lands in the 256 KiB IO aperture goes to the same downstream channel as an IO-space access. Its address is built from the upper bits of the IO base and the offset inside the aperture. The block serves one CPU access at a time. A downstream access holds the CPU response until the downstream acknowledge arrives. The block also folds the interrupt lines of the devices onto four level outputs, chosen by slot number.

Top module: `pci_hb_regs`

## Requirements
- R1: After reset, header word 0 (offset 0x000) reads {DEVICE_ID, VENDOR_ID} = 0x2C01_1AB7. Header word 1 (offset 0x004) reads 0x0290_0080: the command half has only bit 7 set, and the status half has bits 4, 7 and 9 set. All other header words read 0, the three bridge registers read 0, and cpu_ack, ds_req and irq_out are low.
- R2: Offsets 0x000 to 0x0FC with word alignment are 64 header words that are fully writable and readable, 32 bits at a time, with byte 0 in bits [7:0].
- R3: Offset 0x1C0 holds the configuration address. All 32 bits are stored and read back.
- R4: Offset 0x1C4 holds the memory base. A write stores wdata & 0xFF00_0001, and a read returns the stored value.
- R5: Offset 0x1C8 holds the IO base. A write stores wdata & 0xFFFC_0001, and a read returns the stored value.
- R6: A write to offset 0x220 raises ds_req with ds_space = 0 (configuration), ds_we = 1, ds_be = 4'hF, ds_addr = configuration address and ds_wdata = CPU data. ds_req falls at the edge that samples ds_ack high, and cpu_ack rises for one cycle at that same edge.
- R7: A read of offset 0x220 issues the same transaction with ds_we = 0. cpu_rdata during cpu_ack equals the ds_rdata sampled with ds_ack.
- R8: Window accesses with cpu_be other than 4'hF, with cpu_addr[1:0] not zero, or at an offset that is not one of the registers above read 0 and change nothing. Every access that stays local is acknowledged in the cycle after it is accepted, and cpu_ack is high for exactly one cycle.
- R9: Window A (WIN_A_BASE) and window B (WIN_B_BASE) decode offsets 0x000 to 0x223 the same way and share the same state.
- R10: An access at AP_BASE + off, where off is below 0x40000, raises ds_req with ds_space = 1 (IO), ds_addr = {io_base[31:18], off[17:0]}, and with cpu_we, cpu_wdata and cpu_be passed through.
- R11: Only one downstream access is outstanding at a time. ds_req and all ds_* fields stay steady until ds_ack, and ds_req and cpu_ack are never high together.
- R12: irq_out[k] is the OR of dev_irq[i] over every device slot i with i mod 4 = k. It follows the inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access request, held until cpu_ack |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_be | input | 4 | CPU byte enables |
| cpu_ack | output | 1 | One-cycle access completion |
| cpu_rdata | output | 32 | Read data, valid with cpu_ack |
| ds_req | output | 1 | Downstream request, held until ds_ack |
| ds_space | output | 1 | 0 = configuration, 1 = IO |
| ds_we | output | 1 | Downstream write |
| ds_addr | output | 32 | Downstream address |
| ds_wdata | output | 32 | Downstream write data |
| ds_be | output | 4 | Downstream byte enables |
| ds_ack | input | 1 | Downstream acknowledge |
| ds_rdata | input | 32 | Downstream read data, sampled with ds_ack |
| dev_irq | input | NDEV | Interrupt level per device slot |
| irq_out | output | NIRQ | Routed interrupt levels |

## Verification
Interrupt routing has no clock and is fully independent of the bus sequencer. Its outputs can therefore change in the same cycle that a downstream acknowledge arrives or that a register write takes effect. To provoke this, the bench changes dev_irq on every clock from a separate process while a configuration write stalls with several cycles of downstream latency. On every clock it compares irq_out with its own OR-by-slot model. It also checks that the stalled request keeps its address and data, and that the CPU response comes exactly one cycle after the acknowledge.

// File: rtl/pci_hb_pkg.sv
package pci_hb_pkg;

    localparam int unsigned DW         = 32;
    localparam int unsigned AW         = 32;
    localparam int unsigned BEW        = DW / 8;
    localparam int unsigned HDR_BYTES  = 256;
    localparam int unsigned HDR_WORDS  = HDR_BYTES / BEW;
    localparam int unsigned HWW        = $clog2(HDR_WORDS);
    localparam int unsigned WIN_SPAN   = 12'h224;
    localparam int unsigned WIN_PGW    = 12;
    localparam int unsigned AP_OFFW    = 18;

    localparam logic [11:0] OFF_CADDR  = 12'h1C0;
    localparam logic [11:0] OFF_MBASE  = 12'h1C4;
    localparam logic [11:0] OFF_IOBASE = 12'h1C8;
    localparam logic [11:0] OFF_CDATA  = 12'h220;

    localparam logic [DW-1:0] MBASE_MASK  = 32'hFF00_0001;
    localparam logic [DW-1:0] IOBASE_MASK = 32'hFFFC_0001;
    localparam logic [15:0]   CMD_RESET   = 16'h0080;
    localparam logic [15:0]   STS_RESET   = 16'h0290;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_HDR,
        ACC_CADDR,
        ACC_MBASE,
        ACC_IOBASE,
        ACC_CDATA,
        ACC_APER
    } hb_kind_e;

    typedef enum logic {
        SP_CFG = 1'b0,
        SP_IO  = 1'b1
    } hb_space_e;

    typedef struct packed {
        hb_kind_e               kind;
        logic [HWW-1:0]         word;
        logic [AP_OFFW-1:0]     ap_off;
    } hb_dec_t;

    function automatic hb_dec_t hb_decode(
        input logic [AW-1:0]  addr,
        input logic [BEW-1:0] be,
        input logic [AW-1:0]  win_a,
        input logic [AW-1:0]  win_b,
        input logic [AW-1:0]  ap
    );
        hb_dec_t    d;
        logic       in_win;
        logic [11:0] off;
        d.kind   = ACC_NONE;
        off      = addr[WIN_PGW-1:0];
        d.word   = off[HWW+1:2];
        d.ap_off = addr[AP_OFFW-1:0];
        in_win   = (addr[AW-1:WIN_PGW] == win_a[AW-1:WIN_PGW]) ||
                   (addr[AW-1:WIN_PGW] == win_b[AW-1:WIN_PGW]);
        if (addr[AW-1:AP_OFFW] == ap[AW-1:AP_OFFW]) begin
            d.kind = ACC_APER;
        end else if (in_win && be == '1 && off[1:0] == 2'b00 &&
                     32'(off) < WIN_SPAN) begin
            if (32'(off) < HDR_BYTES)  d.kind = ACC_HDR;
            else if (off == OFF_CADDR)  d.kind = ACC_CADDR;
            else if (off == OFF_MBASE)  d.kind = ACC_MBASE;
            else if (off == OFF_IOBASE) d.kind = ACC_IOBASE;
            else if (off == OFF_CDATA)  d.kind = ACC_CDATA;
        end
        return d;
    endfunction

    function automatic logic [DW-1:0] hdr_reset_word(
        input int unsigned idx,
        input logic [15:0] vid,
        input logic [15:0] did
    );
        if (idx == 0) return {did, vid};
        if (idx == 1) return {STS_RESET, CMD_RESET};
        return '0;
    endfunction

endpackage

// File: rtl/hb_cfg_hdr.sv
module hb_cfg_hdr
    import pci_hb_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1AB7,
    parameter logic [15:0] DEVICE_ID = 16'h2C01
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [HWW-1:0]  waddr,
    input  logic [DW-1:0]   wdata,
    input  logic [HWW-1:0]  raddr,
    output logic [DW-1:0]   rdata
);

    logic [DW-1:0] words [HDR_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HDR_WORDS; i++) begin
                words[i] <= hdr_reset_word(i, VENDOR_ID, DEVICE_ID);
            end
        end else if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign rdata = words[raddr];

    // R1: first cycle out of reset shows the reset header
    a_r1_hdr_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (words[1] == {STS_RESET, CMD_RESET}));

    // R2: a header write lands in the addressed word
    a_r2_hdr_write: assert property (@(posedge clk) disable iff (rst)
        we |=> (words[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/hb_base_regs.sv
module hb_base_regs
    import pci_hb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_caddr,
    input  logic          wr_mbase,
    input  logic          wr_iobase,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] caddr,
    output logic [DW-1:0] mbase,
    output logic [DW-1:0] iobase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            caddr  <= '0;
            mbase  <= '0;
            iobase <= '0;
        end else begin
            if (wr_caddr)  caddr  <= wdata;
            if (wr_mbase)  mbase  <= wdata & MBASE_MASK;
            if (wr_iobase) iobase <= wdata & IOBASE_MASK;
        end
    end

    a_r3_caddr_full: assert property (@(posedge clk) disable iff (rst)
        wr_caddr |=> (caddr == $past(wdata)));

    a_r4_mbase_drop: assert property (@(posedge clk) disable iff (rst)
        wr_mbase |=> (mbase[23:1] == '0 && mbase[31:24] == $past(wdata[31:24])));

    a_r5_iobase_drop: assert property (@(posedge clk) disable iff (rst)
        wr_iobase |=> (iobase[17:1] == '0 && iobase[0] == $past(wdata[0])));

endmodule

// File: rtl/hb_irq_route.sv
module hb_irq_route #(
    parameter int unsigned NDEV = 8,
    parameter int unsigned NIRQ = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NDEV-1:0] dev_irq,
    output logic [NIRQ-1:0] irq_out
);

    for (genvar k = 0; k < NIRQ; k++) begin : g_line
        always_comb begin
            irq_out[k] = 1'b0;
            for (int i = 0; i < NDEV; i++) begin
                if ((i % NIRQ) == k) irq_out[k] = irq_out[k] | dev_irq[i];
            end
        end
    end

    // R12: no source active means every line is low
    a_r12_quiet: assert property (@(posedge clk) disable iff (rst)
        (dev_irq == '0) |-> (irq_out == '0));

    // R12: an active line needs at least one active source
    a_r12_source: assert property (@(posedge clk) disable iff (rst)
        (irq_out != '0) |-> (dev_irq != '0));

endmodule

// File: rtl/hb_bus_ctl.sv
module hb_bus_ctl
    import pci_hb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cpu_req,
    input  logic                 cpu_we,
    input  logic [AW-1:0]        cpu_addr,
    input  logic [DW-1:0]        cpu_wdata,
    input  logic [BEW-1:0]       cpu_be,
    input  hb_dec_t              dec,
    input  logic [DW-1:0]        loc_rdata,
    input  logic [DW-1:0]        cfg_addr,
    input  logic [AW-1:AP_OFFW]  io_win,
    output logic                 loc_wr,
    output logic                 cpu_ack,
    output logic [DW-1:0]        cpu_rdata,
    output logic                 ds_req,
    output logic                 ds_space,
    output logic                 ds_we,
    output logic [AW-1:0]        ds_addr,
    output logic [DW-1:0]        ds_wdata,
    output logic [BEW-1:0]       ds_be,
    input  logic                 ds_ack,
    input  logic [DW-1:0]        ds_rdata
);

    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RESP} st_e;

    st_e           state;
    logic [DW-1:0] rdata_q;
    logic          accept;
    logic          goes_down;

    assign accept    = (state == ST_IDLE) && cpu_req;
    assign goes_down = (dec.kind == ACC_CDATA) || (dec.kind == ACC_APER);
    assign loc_wr    = accept && cpu_we && !goes_down;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            rdata_q  <= '0;
            ds_space <= SP_CFG;
            ds_we    <= 1'b0;
            ds_addr  <= '0;
            ds_wdata <= '0;
            ds_be    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (cpu_req) begin
                    if (goes_down) begin
                        state    <= ST_WAIT;
                        ds_we    <= cpu_we;
                        ds_wdata <= cpu_wdata;
                        if (dec.kind == ACC_CDATA) begin
                            ds_space <= SP_CFG;
                            ds_addr  <= cfg_addr;
                            ds_be    <= '1;
                        end else begin
                            ds_space <= SP_IO;
                            ds_addr  <= {io_win, dec.ap_off};
                            ds_be    <= cpu_be;
                        end
                    end else begin
                        state   <= ST_RESP;
                        rdata_q <= cpu_we ? '0 : loc_rdata;
                    end
                end
                ST_WAIT: if (ds_ack) begin
                    state   <= ST_RESP;
                    rdata_q <= ds_we ? '0 : ds_rdata;
                end
                ST_RESP: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ds_req    = (state == ST_WAIT);
    assign cpu_ack   = (state == ST_RESP);
    assign cpu_rdata = rdata_q;

    a_r6_ack_follows: assert property (@(posedge clk) disable iff (rst)
        (ds_req && ds_ack) |=> (cpu_ack && !ds_req));

    a_r7_read_capture: assert property (@(posedge clk) disable iff (rst)
        (ds_req && ds_ack && !ds_we) |=> (cpu_rdata == $past(ds_rdata)));

    a_r8_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |=> !cpu_ack);

    a_r10_ap_offset: assert property (@(posedge clk) disable iff (rst)
        (accept && dec.kind == ACC_APER) |=>
            (ds_req && ds_space == SP_IO && ds_addr[AP_OFFW-1:0] == $past(cpu_addr[AP_OFFW-1:0])));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (ds_req && !ds_ack) |=>
            (ds_req && $stable(ds_addr) && $stable(ds_wdata) && $stable(ds_be) && $stable(ds_space)));

    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ds_req && cpu_ack));

endmodule

// File: rtl/pci_hb_regs.sv
module pci_hb_regs
    import pci_hb_pkg::*;
#(
    parameter logic [31:0] WIN_A_BASE = 32'hFE20_0000,
    parameter logic [31:0] WIN_B_BASE = 32'h1E20_0000,
    parameter logic [31:0] AP_BASE    = 32'hFE24_0000,
    parameter logic [15:0] VENDOR_ID  = 16'h1AB7,
    parameter logic [15:0] DEVICE_ID  = 16'h2C01,
    parameter int unsigned NDEV       = 8,
    parameter int unsigned NIRQ       = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cpu_req,
    input  logic            cpu_we,
    input  logic [31:0]     cpu_addr,
    input  logic [31:0]     cpu_wdata,
    input  logic [3:0]      cpu_be,
    output logic            cpu_ack,
    output logic [31:0]     cpu_rdata,
    output logic            ds_req,
    output logic            ds_space,
    output logic            ds_we,
    output logic [31:0]     ds_addr,
    output logic [31:0]     ds_wdata,
    output logic [3:0]      ds_be,
    input  logic            ds_ack,
    input  logic [31:0]     ds_rdata,
    input  logic [NDEV-1:0] dev_irq,
    output logic [NIRQ-1:0] irq_out
);

    hb_dec_t       dec;
    logic          loc_wr;
    logic [DW-1:0] hdr_rd, caddr, mbase, iobase, loc_rdata;

    assign dec = hb_decode(cpu_addr, cpu_be, WIN_A_BASE, WIN_B_BASE, AP_BASE);

    always_comb begin
        unique case (dec.kind)
            ACC_HDR:    loc_rdata = hdr_rd;
            ACC_CADDR:  loc_rdata = caddr;
            ACC_MBASE:  loc_rdata = mbase;
            ACC_IOBASE: loc_rdata = iobase;
            default:    loc_rdata = '0;
        endcase
    end

    hb_cfg_hdr #(.VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)) u_hdr (
        .clk   (clk),
        .rst   (rst),
        .we    (loc_wr && dec.kind == ACC_HDR),
        .waddr (dec.word),
        .wdata (cpu_wdata),
        .raddr (dec.word),
        .rdata (hdr_rd)
    );

    hb_base_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_caddr  (loc_wr && dec.kind == ACC_CADDR),
        .wr_mbase  (loc_wr && dec.kind == ACC_MBASE),
        .wr_iobase (loc_wr && dec.kind == ACC_IOBASE),
        .wdata     (cpu_wdata),
        .caddr     (caddr),
        .mbase     (mbase),
        .iobase    (iobase)
    );

    hb_bus_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_be    (cpu_be),
        .dec       (dec),
        .loc_rdata (loc_rdata),
        .cfg_addr  (caddr),
        .io_win    (iobase[AW-1:AP_OFFW]),
        .loc_wr    (loc_wr),
        .cpu_ack   (cpu_ack),
        .cpu_rdata (cpu_rdata),
        .ds_req    (ds_req),
        .ds_space  (ds_space),
        .ds_we     (ds_we),
        .ds_addr   (ds_addr),
        .ds_wdata  (ds_wdata),
        .ds_be     (ds_be),
        .ds_ack    (ds_ack),
        .ds_rdata  (ds_rdata)
    );

    hb_irq_route #(.NDEV(NDEV), .NIRQ(NIRQ)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .dev_irq (dev_irq),
        .irq_out (irq_out)
    );

endmodule

// File: tb/pci_hb_regs_tb.sv
`timescale 1ns/1ps
module pci_hb_regs_tb;

    localparam logic [31:0] WA = 32'hFE20_0000;
    localparam logic [31:0] WB = 32'h1E20_0000;
    localparam logic [31:0] AP = 32'hFE24_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 0, cpu_we = 0;
    logic [31:0] cpu_addr = 0, cpu_wdata = 0;
    logic [3:0]  cpu_be = 0;
    logic        cpu_ack;
    logic [31:0] cpu_rdata;
    logic        ds_req, ds_space, ds_we;
    logic [31:0] ds_addr, ds_wdata;
    logic [3:0]  ds_be;
    logic        ds_ack = 0;
    logic [31:0] ds_rdata = 0;
    logic [7:0]  dev_irq = 0;
    logic [3:0]  irq_out;

    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    pci_hb_regs u_dut (.*);

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ds_model(input logic sp, input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ (sp ? 32'h5A5A_5A5A : 32'h0F0F_0F0F);
    endfunction

    // downstream responder with adjustable latency
    int          ds_lat = 1;
    int          ds_cnt = 0;
    int          ds_seen = 0;
    bit          ds_moved = 0;
    logic        r_space, r_we;
    logic [31:0] r_addr, r_wdata;
    logic [3:0]  r_be;

    always @(negedge clk) begin
        if (ds_ack) begin
            ds_ack = 1'b0;
        end else if (ds_req) begin
            if (ds_cnt == 0) begin
                r_space = ds_space; r_we = ds_we; r_addr = ds_addr;
                r_wdata = ds_wdata; r_be = ds_be; ds_moved = 0;
            end else if (ds_addr != r_addr || ds_wdata != r_wdata ||
                         ds_be != r_be || ds_space != r_space) begin
                ds_moved = 1;
            end
            ds_cnt++;
            if (ds_cnt >= ds_lat) begin
                ds_ack   = 1'b1;
                ds_rdata = ds_model(ds_space, ds_addr);
                ds_cnt   = 0;
                ds_seen++;
            end
        end
    end

    // R12 reference: per-clock OR-by-slot model
    always @(negedge clk) begin
        if (!rst) begin
            logic [3:0] e;
            e = '0;
            for (int i = 0; i < 8; i++) e[i % 4] = e[i % 4] | dev_irq[i];
            check(irq_out == e, "R12 irq routing", {28'h0, irq_out}, {28'h0, e});
        end
    end

    task automatic xfer(input bit we, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] be, output logic [31:0] rd, output int waited);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!cpu_ack && waited < 100);
        rd = cpu_rdata;
        cpu_req = 0; cpu_we = 0;
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        logic [31:0] rd; int w;
        xfer(1, a, d, be, rd, w);
        check(w == 1, "R8 local write latency", w, 1);
    endtask

    task automatic rd_chk(input logic [31:0] a, input logic [31:0] exp, input logic [3:0] be, input string tag);
        logic [31:0] rd; int w;
        xfer(0, a, 0, be, rd, w);
        check(w == 1, "R8 local read latency", w, 1);
        check(rd == exp, tag, rd, exp);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        int w;
        repeat (4) @(posedge clk);
        rst = 0;
        @(negedge clk);
        check(!cpu_ack && !ds_req, "R1 reset outputs", {cpu_ack, ds_req}, 0);
        // R1 reset contents
        rd_chk(WA + 12'h000, 32'h2C01_1AB7, 4'hF, "R1 id word");
        rd_chk(WA + 12'h004, 32'h0290_0080, 4'hF, "R1 command/status");
        rd_chk(WA + 12'h014, 32'h0, 4'hF, "R1 header zero");
        rd_chk(WA + 12'h1C8, 32'h0, 4'hF, "R1 io base zero");
        // R2 header words
        wr(WA + 12'h010, 32'hDEAD_BEEF, 4'hF);
        rd_chk(WA + 12'h010, 32'hDEAD_BEEF, 4'hF, "R2 header rw");
        wr(WA + 12'h0FC, 32'h0123_4567, 4'hF);
        rd_chk(WA + 12'h0FC, 32'h0123_4567, 4'hF, "R2 last header word");
        // R3
        wr(WA + 12'h1C0, 32'h8000_1234, 4'hF);
        rd_chk(WA + 12'h1C0, 32'h8000_1234, 4'hF, "R3 config address");
        // R4
        wr(WA + 12'h1C4, 32'hFFFF_FFFF, 4'hF);
        rd_chk(WA + 12'h1C4, 32'hFF00_0001, 4'hF, "R4 mem base mask ones");
        wr(WA + 12'h1C4, 32'h1234_5670, 4'hF);
        rd_chk(WA + 12'h1C4, 32'h1200_0000, 4'hF, "R4 mem base mask pattern");
        // R5
        wr(WA + 12'h1C8, 32'hFFFF_FFFF, 4'hF);
        rd_chk(WA + 12'h1C8, 32'hFFFC_0001, 4'hF, "R5 io base mask");
        // R8 illegal accesses
        wr(WA + 12'h200, 32'hFFFF_FFFF, 4'hF);
        rd_chk(WA + 12'h200, 32'h0, 4'hF, "R8 hole reads zero");
        rd_chk(WA + 12'h224, 32'h0, 4'hF, "R8 past window");
        wr(WA + 12'h1C0, 32'h5555_5555, 4'h3);
        rd_chk(WA + 12'h1C0, 32'h8000_1234, 4'hF, "R8 partial write ignored");
        rd_chk(WA + 12'h1C0, 32'h0, 4'h3, "R8 partial read zero");
        rd_chk(WA + 12'h1C2, 32'h0, 4'hF, "R8 misaligned read zero");
        // R9 alias
        wr(WB + 12'h020, 32'hCAFE_F00D, 4'hF);
        rd_chk(WA + 12'h020, 32'hCAFE_F00D, 4'hF, "R9 alias B->A");
        rd_chk(WB + 12'h1C4, 32'h1200_0000, 4'hF, "R9 alias register");
        rd_chk(WB + 12'h010, 32'hDEAD_BEEF, 4'hF, "R9 alias header");
        // R6 + R11: stalled config write with irq churn alongside
        ds_lat = 4;
        fork
            xfer(1, WA + 12'h220, 32'h7777_1111, 4'hF, rd, w);
            begin
                for (int t = 0; t < 8; t++) begin
                    @(posedge clk);
                    dev_irq <= 8'(t * 37 + 5);
                end
            end
        join
        check(w == ds_lat + 1, "R6 ack after downstream ack", w, ds_lat + 1);
        check(r_space == 0 && r_we == 1 && r_be == 4'hF, "R6 config write fields",
              {r_space, r_we, r_be}, 6'b01_1111);
        check(r_addr == 32'h8000_1234, "R6 config address", r_addr, 32'h8000_1234);
        check(r_wdata == 32'h7777_1111, "R6 config data", r_wdata, 32'h7777_1111);
        check(!ds_moved, "R11 request steady", ds_moved, 0);
        // R7 config read
        ds_lat = 2;
        wr(WA + 12'h1C0, 32'h0000_0A0C, 4'hF);
        xfer(0, WB + 12'h220, 0, 4'hF, rd, w);
        check(rd == ds_model(0, 32'h0000_0A0C), "R7 config read data", rd, ds_model(0, 32'h0000_0A0C));
        check(r_we == 0 && r_addr == 32'h0000_0A0C, "R7 config read issued", r_addr, 32'h0000_0A0C);
        check(w == 3, "R7 read latency", w, 3);
        // R10 aperture
        wr(WA + 12'h1C8, 32'h0ABC_0000, 4'hF);
        ds_lat = 1;
        xfer(0, AP + 32'h1_2344, 0, 4'hF, rd, w);
        check(r_space == 1 && r_addr == 32'h0ABD_2344, "R10 aperture address", r_addr, 32'h0ABD_2344);
        check(rd == ds_model(1, 32'h0ABD_2344), "R10 aperture read", rd, ds_model(1, 32'h0ABD_2344));
        xfer(1, AP + 32'h3_FFFC, 32'h1357_9BDF, 4'b0110, rd, w);
        check(r_addr == 32'h0ABF_FFFC && r_we == 1, "R10 aperture write addr", r_addr, 32'h0ABF_FFFC);
        check(r_be == 4'b0110 && r_wdata == 32'h1357_9BDF, "R10 aperture be/data", {28'h0, r_be}, 32'h6);
        check(ds_seen == 4, "R11 one request per access", ds_seen, 4);
        // R12 static patterns
        for (int p = 0; p < 4; p++) begin
            @(posedge clk);
            dev_irq <= 8'h1 << (p + 4);
            @(negedge clk);
        end
        @(posedge clk);
        dev_irq <= 8'h00;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule